// File: doc/BRIEF.md
# Conversion Result Buffer with Two-Byte Read Formatter

This block sits between an analog-to-digital converter and the byte engine of a two-wire serial target. Each 10-bit result arrives with a one-cycle valid strobe and is stored in arrival order. The buffer holds up to twelve results, which is one full scan.

The serial side asks for one byte at a time. Each stored result goes out as two bytes. The upper byte carries six filler ones above the two top result bits. The lower byte carries the remaining eight bits. Only the next result in conversion order can be read; there is no addressed read.

After every byte the master answers with acknowledge or not-acknowledge. A not-acknowledge closes the transfer. A stop or a repeated start on the bus empties the buffer so the next transaction starts fresh. A request that finds no unread result is answered with all-ones, which is what an idle pulled-up data line reads as, and raises a one-cycle underflow flag.

Top module: `adcbuf_top`

## Requirements
- R1: Results are returned in the order they were written; a later result is never sent before an earlier unread one.
- R2: The first byte of a result is {6'b111111, result[9:8]}: bits 7..2 are ones and bits 1..0 hold the two top result bits.
- R3: The second byte of a result is result[7:0]. Only after the second byte is sent does the read position move to the next result.
- R4: `byte_o` takes its new value on the clock edge that samples `byte_req_i` high and holds that value while no request is made.
- R5: A cycle with `mst_ack_valid_i`=1 and `mst_nack_i`=1 ends the transfer. Until the next stop or repeated start, every request returns 8'hFF, does not move the read position and does not raise `underflow_o`. An acknowledge (`mst_nack_i`=0) has no effect.
- R6: A `bus_stop_i` or `bus_rstart_i` pulse empties the buffer and resets the byte order to the first byte. A write in the same cycle is discarded.
- R7: A first-byte request made when no unread result is stored returns 8'hFF and raises `underflow_o` for exactly the next cycle; the byte order does not advance.
- R8: A write made while twelve results are already stored is dropped, and the stored results are unchanged.
- R9: After reset, `byte_o` is 8'hFF, `underflow_o` is 0 and the buffer holds no results. Stored results stay readable for any number of idle cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| res_valid_i | input | 1 | Result write strobe |
| res_data_i | input | 10 | Conversion result |
| byte_req_i | input | 1 | Request for the next byte (one-cycle pulse) |
| byte_o | output | 8 | Byte answered to the last request |
| mst_ack_valid_i | input | 1 | Master response strobe |
| mst_nack_i | input | 1 | Response is not-acknowledge when 1 |
| bus_stop_i | input | 1 | Stop condition seen on the bus |
| bus_rstart_i | input | 1 | Repeated start seen on the bus |
| underflow_o | output | 1 | One-cycle flag: a request found no unread result |

## Verification
The assertions assume that `byte_req_i` is a single-cycle pulse and that it never falls in the same cycle as a master response or a bus condition. They also assume that the read position can only trail the write position or catch up with it, and never pass it. The bench drives each request, response, write and bus event as its own one-cycle pulse from a task. It always separates a request from its response by at least one idle edge. The only overlaps it allows on purpose are a write in the same cycle as a stop or repeated start, and writes beyond twelve.

// File: rtl/adcbuf_pkg.sv
package adcbuf_pkg;

    // Which half of a stored result the next request will return
    typedef enum logic {
        PH_HI = 1'b0,
        PH_LO = 1'b1
    } phase_e;

    localparam int BYTE_W = 8;

endpackage

// File: rtl/adcbuf_store.sv
// Linear result store: written from index 0 upward, emptied only by clear.
module adcbuf_store #(
    parameter  int DEPTH = 12,
    parameter  int RES_W = 10,
    localparam int PTR_W = $clog2(DEPTH + 1),
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             clear_i,
    input  logic             wr_valid_i,
    input  logic [RES_W-1:0] wr_data_i,
    input  logic [PTR_W-1:0] rd_pos_i,
    output logic [PTR_W-1:0] wr_pos_o,
    output logic [RES_W-1:0] rd_data_o
);

    localparam logic [PTR_W-1:0] FULL_P = PTR_W'(DEPTH);

    typedef struct packed {
        logic [PTR_W-1:0] wpos;
    } st_t;

    st_t st_d, st_q;
    logic             wen;
    logic [IDX_W-1:0] widx;

    // Contents are deliberately left without reset: undefined after power-up.
    logic [RES_W-1:0] mem_q [DEPTH];

    always_comb begin
        st_d = st_q;
        wen  = 1'b0;
        widx = st_q.wpos[IDX_W-1:0];
        if (clear_i) begin
            st_d.wpos = '0;
        end else if (wr_valid_i && (st_q.wpos < FULL_P)) begin
            wen       = 1'b1;
            st_d.wpos = st_q.wpos + 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_ff @(posedge clk_i) begin
        if (wen) begin
            mem_q[widx] <= wr_data_i;
        end
    end

    always_comb begin
        if (rd_pos_i < FULL_P) begin
            rd_data_o = mem_q[rd_pos_i[IDX_W-1:0]];
        end else begin
            rd_data_o = '0;
        end
    end

    assign wr_pos_o = st_q.wpos;

endmodule

// File: rtl/adcbuf_fmt.sv
// Read sequencer: splits each result into a padded upper byte and a lower byte.
module adcbuf_fmt
    import adcbuf_pkg::*;
#(
    parameter  int DEPTH = 12,
    parameter  int RES_W = 10,
    localparam int PTR_W = $clog2(DEPTH + 1),
    localparam int HI_W  = RES_W - BYTE_W,
    localparam int PAD_W = 2 * BYTE_W - RES_W
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              clear_i,
    input  logic              req_i,
    input  logic              rsp_valid_i,
    input  logic              rsp_nack_i,
    input  logic [PTR_W-1:0]  wr_pos_i,
    input  logic [RES_W-1:0]  rd_data_i,
    output logic [PTR_W-1:0]  rd_pos_o,
    output logic [BYTE_W-1:0] byte_o,
    output logic              uflow_o,
    output logic              closed_o
);

    typedef struct packed {
        logic [PTR_W-1:0]  rpos;
        phase_e            phase;
        logic              closed;
        logic [BYTE_W-1:0] dout;
        logic              uflow;
    } st_t;

    st_t st_d, st_q;
    logic have_unread;

    assign have_unread = (st_q.rpos < wr_pos_i);

    always_comb begin
        st_d       = st_q;
        st_d.uflow = 1'b0;
        if (clear_i) begin
            st_d.rpos   = '0;
            st_d.phase  = PH_HI;
            st_d.closed = 1'b0;
        end else begin
            if (rsp_valid_i && rsp_nack_i) begin
                st_d.closed = 1'b1;
            end
            if (req_i) begin
                if (st_q.closed) begin
                    st_d.dout = '1;
                end else if (st_q.phase == PH_HI) begin
                    if (have_unread) begin
                        st_d.dout  = {{PAD_W{1'b1}}, rd_data_i[RES_W-1:BYTE_W]};
                        st_d.phase = PH_LO;
                    end else begin
                        st_d.dout  = '1;
                        st_d.uflow = 1'b1;
                    end
                end else begin
                    st_d.dout  = rd_data_i[BYTE_W-1:0];
                    st_d.rpos  = st_q.rpos + 1'b1;
                    st_d.phase = PH_HI;
                end
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q.rpos   <= '0;
            st_q.phase  <= PH_HI;
            st_q.closed <= 1'b0;
            st_q.dout   <= '1;
            st_q.uflow  <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_pos_o = st_q.rpos;
    assign byte_o   = st_q.dout;
    assign uflow_o  = st_q.uflow;
    assign closed_o = st_q.closed;

    // Upper byte must carry at least one result bit and some padding
    if (HI_W < 1 || PAD_W < 1) begin : g_bad_width
        initial $error("adcbuf_fmt: RES_W must lie between 9 and 15");
    end

endmodule

// File: rtl/adcbuf_top.sv
module adcbuf_top #(
    parameter  int DEPTH = 12,
    parameter  int RES_W = 10,
    localparam int PTR_W = $clog2(DEPTH + 1)
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             res_valid_i,
    input  logic [RES_W-1:0] res_data_i,
    input  logic             byte_req_i,
    output logic [7:0]       byte_o,
    input  logic             mst_ack_valid_i,
    input  logic             mst_nack_i,
    input  logic             bus_stop_i,
    input  logic             bus_rstart_i,
    output logic             underflow_o
);

    logic             clear;
    logic [PTR_W-1:0] wpos;
    logic [PTR_W-1:0] rpos;
    logic [RES_W-1:0] rdata;
    logic             closed;

    assign clear = bus_stop_i | bus_rstart_i;

    adcbuf_store #(
        .DEPTH(DEPTH),
        .RES_W(RES_W)
    ) u_store (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .clear_i   (clear),
        .wr_valid_i(res_valid_i),
        .wr_data_i (res_data_i),
        .rd_pos_i  (rpos),
        .wr_pos_o  (wpos),
        .rd_data_o (rdata)
    );

    adcbuf_fmt #(
        .DEPTH(DEPTH),
        .RES_W(RES_W)
    ) u_fmt (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .clear_i    (clear),
        .req_i      (byte_req_i),
        .rsp_valid_i(mst_ack_valid_i),
        .rsp_nack_i (mst_nack_i),
        .wr_pos_i   (wpos),
        .rd_data_i  (rdata),
        .rd_pos_o   (rpos),
        .byte_o     (byte_o),
        .uflow_o    (underflow_o),
        .closed_o   (closed)
    );

endmodule

// File: rtl/adcbuf_chk.sv
module adcbuf_chk #(
    parameter  int DEPTH = 12,
    localparam int PTR_W = $clog2(DEPTH + 1)
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic             clear_i,
    input logic             req_i,
    input logic             uflow_i,
    input logic [7:0]       byte_i,
    input logic [PTR_W-1:0] wpos_i,
    input logic [PTR_W-1:0] rpos_i,
    input logic             closed_i
);

    localparam logic [PTR_W-1:0] FULL_P = PTR_W'(DEPTH);

    AST_READ_BEHIND_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rpos_i <= wpos_i);                                             // R1

    AST_READ_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !clear_i |=> (rpos_i == $past(rpos_i)) || (rpos_i == $past(rpos_i) + 1'b1)); // R3

    AST_BYTE_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !req_i |=> $stable(byte_i));                                   // R4

    AST_CLOSED_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (closed_i && !clear_i) |=> $stable(rpos_i) && !uflow_i);       // R5

    AST_CLEAR_EMPTIES: assert property (@(posedge clk_i) disable iff (!rst_ni)
        clear_i |=> (wpos_i == '0) && (rpos_i == '0) && !closed_i);    // R6

    AST_UFLOW_ONES: assert property (@(posedge clk_i) disable iff (!rst_ni)
        uflow_i |-> (byte_i == 8'hFF));                                // R7

    AST_UFLOW_NEEDS_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !req_i |=> !uflow_i);                                          // R7

    AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wpos_i <= FULL_P);                                             // R8

endmodule

bind adcbuf_top adcbuf_chk #(
    .DEPTH(DEPTH)
) u_chk (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (clear),
    .req_i   (byte_req_i),
    .uflow_i (underflow_o),
    .byte_i  (byte_o),
    .wpos_i  (wpos),
    .rpos_i  (rpos),
    .closed_i(closed)
);

// File: tb/adcbuf_top_bench.sv
module adcbuf_top_bench;

    localparam int DEPTH = 12;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       res_valid = 1'b0;
    logic [9:0] res_data = '0;
    logic       byte_req = 1'b0;
    logic [7:0] byte_out;
    logic       ack_valid = 1'b0;
    logic       nack = 1'b0;
    logic       stop = 1'b0;
    logic       rstart = 1'b0;
    logic       uflow;

    int n_chk = 0;
    int n_bad = 0;

    // Reference model
    logic [9:0] m_mem [DEPTH];
    int m_w = 0;
    int m_r = 0;
    bit m_lo = 1'b0;
    bit m_end = 1'b0;

    always #5 clk = ~clk;

    adcbuf_top u_adcbuf_top (
        .clk_i          (clk),
        .rst_ni         (rst_n),
        .res_valid_i    (res_valid),
        .res_data_i     (res_data),
        .byte_req_i     (byte_req),
        .byte_o         (byte_out),
        .mst_ack_valid_i(ack_valid),
        .mst_nack_i     (nack),
        .bus_stop_i     (stop),
        .bus_rstart_i   (rstart),
        .underflow_o    (uflow)
    );

    function automatic logic [7:0] hi_byte(logic [9:0] d);
        return {6'b111111, d[9:8]};
    endfunction

    function automatic logic [7:0] lo_byte(logic [9:0] d);
        return d[7:0];
    endfunction

    task automatic chk(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(logic [9:0] d);
        @(negedge clk);
        res_valid = 1'b1;
        res_data  = d;
        @(negedge clk);
        res_valid = 1'b0;
        if (m_w < DEPTH) begin
            m_mem[m_w] = d;
            m_w++;
        end
    endtask

    task automatic clr(bit use_rstart, bit with_write);
        @(negedge clk);
        if (use_rstart) rstart = 1'b1;
        else            stop   = 1'b1;
        if (with_write) begin
            res_valid = 1'b1;
            res_data  = 10'h155;
        end
        @(negedge clk);
        stop = 1'b0; rstart = 1'b0; res_valid = 1'b0;
        m_w = 0; m_r = 0; m_lo = 1'b0; m_end = 1'b0;
    endtask

    task automatic rsp(bit is_nack);
        @(negedge clk);
        ack_valid = 1'b1;
        nack      = is_nack;
        @(negedge clk);
        ack_valid = 1'b0;
        nack      = 1'b0;
        if (is_nack) m_end = 1'b1;
    endtask

    task automatic rd(string tag_over);
        logic [7:0] eb;
        bit eu;
        string tg;
        eb = 8'hFF;
        eu = 1'b0;
        if (m_end) begin
            tg = "R5";
        end else if (!m_lo) begin
            if (m_r < m_w) begin
                eb = hi_byte(m_mem[m_r]);
                m_lo = 1'b1;
                tg = "R1,R2";
            end else begin
                eu = 1'b1;
                tg = "R7";
            end
        end else begin
            eb = lo_byte(m_mem[m_r]);
            m_r++;
            m_lo = 1'b0;
            tg = "R1,R3";
        end
        if (tag_over != "") tg = tag_over;
        @(negedge clk);
        byte_req = 1'b1;
        @(negedge clk);
        byte_req = 1'b0;
        chk({tg, " byte"}, int'(byte_out), int'(eb));
        chk({tg, " underflow"}, int'(uflow), int'(eu));
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        summary();
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_0042));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R9 reset state
        chk("R9 reset byte", int'(byte_out), 8'hFF);
        chk("R9 reset underflow", int'(uflow), 0);
        rd("R9");

        // Order and formatting over three results, with acknowledges
        wr(10'h3A5); wr(10'h0F0); wr(10'h2C3);
        repeat (6) begin
            rd("");
            rsp(1'b0);
        end
        rd("R7");

        // R4 hold across idle cycles, R9 retention
        clr(1'b0, 1'b0);
        wr(10'h1E7);
        repeat (20) @(negedge clk);
        rd("R9");
        repeat (4) @(negedge clk);
        chk("R4 held byte", int'(byte_out), int'(hi_byte(10'h1E7)));
        rd("");

        // R8 fill beyond depth
        clr(1'b1, 1'b0);
        for (int i = 0; i < DEPTH + 1; i++) wr(10'((i * 83 + 7) % 1024));
        for (int i = 0; i < 2 * DEPTH; i++) begin
            rd(i == 2 * DEPTH - 1 ? "R8" : "");
            rsp(1'b0);
        end
        rd("R8");

        // R5 not-acknowledge ends the transfer
        clr(1'b0, 1'b0);
        wr(10'h2AA); wr(10'h155);
        rd("");
        rsp(1'b1);
        rd("R5");
        rd("R5");
        clr(1'b1, 1'b0);
        wr(10'h0C3);
        rd("R6");
        rd("R6");

        // R6 clear wins over a same-cycle write
        wr(10'h111);
        clr(1'b0, 1'b1);
        rd("R6");
        clr(1'b1, 1'b1);
        rd("R6");

        // Constrained random mix
        for (int n = 0; n < 600; n++) begin
            int op;
            op = int'($urandom_range(0, 99));
            if (op < 35)       wr(10'($urandom_range(0, 1023)));
            else if (op < 85) begin
                rd("");
                rsp($urandom_range(0, 99) < 4);
            end
            else if (op < 93)  @(negedge clk);
            else               clr(bit'($urandom_range(0, 1)), bit'($urandom_range(0, 1)));
        end

        summary();
        $finish;
    end

endmodule